// File: doc/BRIEF.md
# Interleaved Two-Bank Request Crossbar

This block sits between three requesting processor clusters and two cache banks. Each cluster presents at most one memory request per cycle. A request carries a byte address, a data word and a set of control bits. The switch picks the target bank from the lowest bit of the word address. Consecutive 8-byte words therefore fall in alternate banks, and a stream of sequential accesses can keep both banks busy in the same cycle.

Each bank has its own round-robin arbiter. When two or three clusters want the same bank in one cycle, exactly one of them is accepted. The others see their ready low and hold their request until a later cycle grants it. Requests aimed at different banks never interfere with each other.

Each bank port is driven from an output register. An accepted request appears there on the cycle after the handshake. It stays there, unchanged, until the bank takes it. When the bank takes the held request in the same cycle as a new grant, the slot refills at once, so a bank that is always ready accepts one request per cycle.

Top module: `xbar_bank_switch`

## Requirements
- R1: During reset, and in the first cycle after reset is released, no bank port shows a valid request. Both arbiters restart with cluster 0 as the highest-priority requester.
- R2: A request with byte address A goes to bank A[3], which is bit 0 of the word address A>>3. Address bits [2:0] and bits above bit 3 do not affect the routing.
- R3: The address, data and control fields of a request reach the bank port unchanged. Requests to one bank leave it in the order they were accepted.
- R4: Two clusters that target different banks in the same cycle are both accepted in that cycle.
- R5: In any cycle, at most one request is accepted per bank, and req_ready is never high for a cluster whose req_valid is low.
- R6: Each bank arbiter is round-robin. The search starts at the priority pointer and moves upward through cluster numbers, wrapping from 2 to 0. After each grant the pointer moves to the cluster one above the winner, wrapping to 0.
- R7: A request accepted at a clock edge is valid on its bank port after that edge. While bank_ready is low, the bank port keeps its valid, address, data and control stable.
- R8: A bank whose output holds a request while its bank_ready is low accepts no new request. A bank whose held request is taken in a cycle can accept a new request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 3 | Per-cluster request valid |
| req_ready | output | 3 | Per-cluster accept; a request transfers when valid and ready are both high |
| req_addr | input | 3x51 | Per-cluster byte address |
| req_data | input | 3x66 | Per-cluster data word |
| req_ctrl | input | 3x25 | Per-cluster control bits |
| bank_valid | output | 2 | Per-bank request valid (registered) |
| bank_ready | input | 2 | Per-bank accept of the presented request |
| bank_addr | output | 2x51 | Per-bank forwarded address |
| bank_data | output | 2x66 | Per-bank forwarded data |
| bank_ctrl | output | 2x25 | Per-bank forwarded control bits |

## Verification
The crossbar is tested with the input patterns below.
- A single simultaneous pair of requests to opposite banks separates correct parallel routing from a shared grant path, and checks the bank-select bit.
- Three clusters contending for one bank, then a two-cluster case placed so that the pointer skips an idle requester, separate "advance past the winner" from "advance by one" and from fixed priority.
- A stalled bank with traffic still flowing to the other bank checks that the stalled output is held, that the stalled bank's port is blocked, and that the held request and a new grant can change places in the same cycle.
- A long run of random addresses, random request timing and random bank stalls feeds per-bank ordered scoreboards. These catch any lost, duplicated, reordered or misrouted request.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  // a memory word is 8 bytes; the word address starts above these byte bits
  localparam int unsigned WORD_BYTES_LOG2 = 3;

  // index width that never collapses to zero
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_bank_decode.sv
`timescale 1ns/1ps
module xbar_bank_decode #(
  parameter int N_REQ  = 3,
  parameter int N_BANK = 2,
  parameter int BANK_W = 1
) (
  input  logic [N_REQ-1:0]              req_valid,
  input  logic [N_REQ-1:0][BANK_W-1:0]  req_bank,
  output logic [N_BANK-1:0][N_REQ-1:0]  want
);
  // one request line per (bank, requester) pair
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    for (genvar r = 0; r < N_REQ; r++) begin : g_req
      assign want[b][r] = req_valid[r] && (req_bank[r] == BANK_W'(b));
    end
  end
endmodule

// File: rtl/xbar_rr_arb.sv
`timescale 1ns/1ps
module xbar_rr_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          found;

  // first requester at or above the pointer, wrapping around
  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance && found) begin
      ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end
endmodule

// File: rtl/xbar_bank_port.sv
`timescale 1ns/1ps
module xbar_bank_port #(
  parameter int N_REQ = 3,
  parameter int PW    = 142,
  parameter int IW    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_REQ-1:0]             want,
  input  logic [N_REQ-1:0][PW-1:0]     pl_in,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [PW-1:0]                out_pl,
  output logic [N_REQ-1:0]             grant
);
  logic             slot_v;
  logic [PW-1:0]    slot_pl;
  logic [N_REQ-1:0] arb_gnt;
  logic [PW-1:0]    pick;
  logic             open;
  logic             take;

  // slot can load when empty or when its occupant leaves this cycle
  assign open = !slot_v || out_ready;
  assign take = open && (|want);

  xbar_rr_arb #(.N(N_REQ), .IW(IW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (want),
    .advance (take),
    .gnt     (arb_gnt)
  );

  assign grant = open ? arb_gnt : '0;

  // one-hot payload select
  always_comb begin
    pick = '0;
    for (int r = 0; r < N_REQ; r++) begin
      if (arb_gnt[r]) pick = pick | pl_in[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v <= 1'b0;
    end else if (take) begin
      slot_v <= 1'b1;
    end else if (out_ready) begin
      slot_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) slot_pl <= pick;
  end

  assign out_valid = slot_v;
  assign out_pl    = slot_pl;
endmodule

// File: rtl/xbar_bank_switch.sv
`timescale 1ns/1ps
module xbar_bank_switch
  import xbar_pkg::*;
#(
  parameter int N_REQ  = 3,
  parameter int N_BANK = 2,
  parameter int ADDR_W = 51,
  parameter int DATA_W = 66,
  parameter int CTRL_W = 25
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [N_REQ-1:0]                 req_valid,
  output logic [N_REQ-1:0]                 req_ready,
  input  logic [N_REQ-1:0][ADDR_W-1:0]     req_addr,
  input  logic [N_REQ-1:0][DATA_W-1:0]     req_data,
  input  logic [N_REQ-1:0][CTRL_W-1:0]     req_ctrl,
  output logic [N_BANK-1:0]                bank_valid,
  input  logic [N_BANK-1:0]                bank_ready,
  output logic [N_BANK-1:0][ADDR_W-1:0]    bank_addr,
  output logic [N_BANK-1:0][DATA_W-1:0]    bank_data,
  output logic [N_BANK-1:0][CTRL_W-1:0]    bank_ctrl
);
  localparam int BANK_W = int'(idx_w(N_BANK));
  localparam int IW     = int'(idx_w(N_REQ));
  localparam int OFS    = int'(WORD_BYTES_LOG2);
  localparam int PW     = ADDR_W + DATA_W + CTRL_W;

  logic [N_REQ-1:0][BANK_W-1:0] req_bank;
  logic [N_REQ-1:0][PW-1:0]     req_pl;
  logic [N_BANK-1:0][N_REQ-1:0] want;
  logic [N_BANK-1:0][N_REQ-1:0] gnt_b;
  logic [N_BANK-1:0][PW-1:0]    out_pl;

  for (genvar r = 0; r < N_REQ; r++) begin : g_req
    assign req_bank[r] = req_addr[r][OFS +: BANK_W];
    assign req_pl[r]   = {req_ctrl[r], req_data[r], req_addr[r]};
  end

  xbar_bank_decode #(.N_REQ(N_REQ), .N_BANK(N_BANK), .BANK_W(BANK_W)) u_dec (
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .want      (want)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    xbar_bank_port #(.N_REQ(N_REQ), .PW(PW), .IW(IW)) u_port (
      .clk       (clk),
      .rst       (rst),
      .want      (want[b]),
      .pl_in     (req_pl),
      .out_ready (bank_ready[b]),
      .out_valid (bank_valid[b]),
      .out_pl    (out_pl[b]),
      .grant     (gnt_b[b])
    );
    assign bank_addr[b] = out_pl[b][ADDR_W-1:0];
    assign bank_data[b] = out_pl[b][ADDR_W +: DATA_W];
    assign bank_ctrl[b] = out_pl[b][ADDR_W+DATA_W +: CTRL_W];
  end

  // a requester is ready when any bank grants it
  always_comb begin
    req_ready = '0;
    for (int b = 0; b < N_BANK; b++) req_ready = req_ready | gnt_b[b];
  end
endmodule

// File: rtl/xbar_bank_switch_chk.sv
`timescale 1ns/1ps
module xbar_bank_switch_chk #(
  parameter int N_REQ  = 3,
  parameter int N_BANK = 2,
  parameter int ADDR_W = 51,
  parameter int DATA_W = 66,
  parameter int CTRL_W = 25
) (
  input logic                          clk,
  input logic                          rst,
  input logic [N_REQ-1:0]              req_valid,
  input logic [N_REQ-1:0]              req_ready,
  input logic [N_REQ-1:0][ADDR_W-1:0]  req_addr,
  input logic [N_BANK-1:0]             bank_valid,
  input logic [N_BANK-1:0]             bank_ready,
  input logic [N_BANK-1:0][ADDR_W-1:0] bank_addr,
  input logic [N_BANK-1:0][DATA_W-1:0] bank_data,
  input logic [N_BANK-1:0][CTRL_W-1:0] bank_ctrl
);
  localparam int BW = (N_BANK > 1) ? $clog2(N_BANK) : 1;

  logic [N_BANK-1:0][N_REQ-1:0]  acc_m;
  logic [N_BANK-1:0][ADDR_W-1:0] acc_addr;

  // handshakes seen at the ports, sorted by the bank they address
  always_comb begin
    acc_m    = '0;
    acc_addr = '0;
    for (int b = 0; b < N_BANK; b++) begin
      for (int r = 0; r < N_REQ; r++) begin
        if (req_valid[r] && req_ready[r] && (req_addr[r][3 +: BW] == BW'(b))) begin
          acc_m[b][r] = 1'b1;
          acc_addr[b] = acc_addr[b] | req_addr[r];
        end
      end
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_valid == '0));

  for (genvar r = 0; r < N_REQ; r++) begin : g_r
    a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
      req_ready[r] |-> req_valid[r]);
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_b
    a_r5_one_per_bank: assert property (@(posedge clk) disable iff (rst)
      (|req_valid) |-> ($countones(acc_m[b]) <= 1));

    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
      (bank_valid[b] && !bank_ready[b]) |-> (acc_m[b] == '0));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (bank_valid[b] && !bank_ready[b]) |=>
        (bank_valid[b] && $stable(bank_addr[b]) && $stable(bank_data[b]) && $stable(bank_ctrl[b])));

    // R3 and R7: the accepted address shows up on the next cycle
    a_r3_addr_forwarded: assert property (@(posedge clk) disable iff (rst)
      (|acc_m[b]) |=> (bank_valid[b] && (bank_addr[b] == $past(acc_addr[b]))));
  end
endmodule

bind xbar_bank_switch xbar_bank_switch_chk #(
  .N_REQ(N_REQ), .N_BANK(N_BANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .bank_valid (bank_valid),
  .bank_ready (bank_ready),
  .bank_addr  (bank_addr),
  .bank_data  (bank_data),
  .bank_ctrl  (bank_ctrl)
);

// File: tb/tb_xbar_bank_switch.sv
`timescale 1ns/1ps
module tb_xbar_bank_switch;
  typedef struct {
    logic [50:0] a;
    logic [65:0] d;
    logic [24:0] c;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       req_valid = '0;
  logic [2:0]       req_ready;
  logic [2:0][50:0] req_addr = '0;
  logic [2:0][65:0] req_data = '0;
  logic [2:0][24:0] req_ctrl = '0;
  logic [1:0]       bank_valid;
  logic [1:0]       bank_ready = 2'b11;
  logic [1:0][50:0] bank_addr;
  logic [1:0][65:0] bank_data;
  logic [1:0][24:0] bank_ctrl;

  int checks = 0;
  int errors = 0;
  int seq    = 0;

  // driver state: pending request per cluster, bank-ready pattern
  logic [2:0]       pv = '0;
  logic [2:0][50:0] pa;
  logic [2:0][65:0] pd;
  logic [2:0][24:0] pc;
  logic [1:0]       br = 2'b11;
  logic [2:0]       acc;
  logic [1:0]       stall_seen;

  item_t qb0[$];
  item_t qb1[$];

  always #2.5 clk = ~clk;

  xbar_bank_switch dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_ctrl(req_ctrl),
    .bank_valid(bank_valid), .bank_ready(bank_ready),
    .bank_addr(bank_addr), .bank_data(bank_data), .bank_ctrl(bank_ctrl)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int c, input logic [50:0] addr);
    pv[c] = 1'b1;
    pa[c] = addr;
    pd[c] = {2'(c), 32'(seq), 32'($urandom())};
    pc[c] = 25'($urandom());
    seq++;
  endtask

  // driver: one cycle of stimulus; expected items go into the bank queues
  task automatic step();
    @(negedge clk);
    req_valid  = pv;
    req_addr   = pa;
    req_data   = pd;
    req_ctrl   = pc;
    bank_ready = br;
    #1;
    stall_seen = bank_valid & ~bank_ready;
    acc = req_valid & req_ready;
    for (int b = 0; b < 2; b++) begin
      int cnt;
      cnt = 0;
      for (int c = 0; c < 3; c++) if (acc[c] && (req_addr[c][3] == b[0])) cnt++;
      chk(cnt <= 1, "R5 accepts per bank", 64'(cnt), 64'd1);
      if (stall_seen[b]) chk(cnt == 0, "R8 stalled bank accepted", 64'(cnt), 64'd0);
    end
    chk((req_ready & ~req_valid) == '0, "R5 ready without valid", 64'(req_ready), 64'(req_valid));
    for (int c = 0; c < 3; c++) begin
      if (acc[c]) begin
        item_t it;
        it.a = req_addr[c]; it.d = req_data[c]; it.c = req_ctrl[c];
        if (req_addr[c][3]) qb1.push_back(it); else qb0.push_back(it);
      end
    end
    pv = pv & ~acc;
  endtask

  // monitor: pops the bank queues as the bank ports hand requests over
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        for (int b = 0; b < 2; b++) begin
          if (bank_valid[b] && bank_ready[b]) begin
            item_t e;
            if ((b == 0 && qb0.size() == 0) || (b == 1 && qb1.size() == 0)) begin
              chk(1'b0, "R3 unexpected bank output", 64'(bank_addr[b]), 64'd0);
            end else begin
              e = (b == 0) ? qb0.pop_front() : qb1.pop_front();
              chk(bank_addr[b] == e.a, "R2/R3 bank address", 64'(bank_addr[b]), 64'(e.a));
              chk(bank_data[b] == e.d, "R3 bank data", bank_data[b][63:0], e.d[63:0]);
              chk(bank_ctrl[b] == e.c, "R3 bank ctrl", 64'(bank_ctrl[b]), 64'(e.c));
            end
          end
        end
      end
    end
  end

  task automatic drain();
    br = 2'b11;
    pv = '0;
    for (int i = 0; i < 40; i++) begin
      if (qb0.size() == 0 && qb1.size() == 0 && pv == '0) break;
      step();
    end
    step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pv = '0;
    req_valid = '0;
    br = 2'b11;
    bank_ready = br;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(bank_valid == 2'b00, "R1 bank_valid after reset", 64'(bank_valid), 64'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [65:0] held_d;
    do_reset();

    // R4/R2: opposite banks in the same cycle
    set_req(0, 51'h0);
    set_req(1, 51'h8);
    step();
    chk(acc == 3'b011, "R4 both accepted", 64'(acc), 64'h3);
    step();
    chk(bank_valid == 2'b11, "R7 valid next cycle", 64'(bank_valid), 64'h3);
    chk(bank_addr[0] == 51'h0, "R2 word 0 to bank 0", 64'(bank_addr[0]), 64'h0);
    chk(bank_addr[1] == 51'h8, "R2 word 1 to bank 1", 64'(bank_addr[1]), 64'h8);

    // R2: byte offset and higher bits ignored for routing
    set_req(0, 51'h1C);
    set_req(2, 51'h14);
    step();
    chk(acc == 3'b101, "R2 0x1C bank1, 0x14 bank0", 64'(acc), 64'h5);
    step();
    chk(bank_addr[1] == 51'h1C, "R2 0x1C on bank 1", 64'(bank_addr[1]), 64'h1C);
    chk(bank_addr[0] == 51'h14, "R2 0x14 on bank 0", 64'(bank_addr[0]), 64'h14);
    drain();

    // R6: three clusters contend for bank 0
    do_reset();
    set_req(0, 51'h00);
    set_req(1, 51'h10);
    set_req(2, 51'h20);
    step(); chk(acc == 3'b001, "R6 first grant cluster0", 64'(acc), 64'h1);
    step(); chk(acc == 3'b010, "R6 second grant cluster1", 64'(acc), 64'h2);
    step(); chk(acc == 3'b100, "R6 third grant cluster2", 64'(acc), 64'h4);
    set_req(0, 51'h30);
    set_req(2, 51'h40);
    step(); chk(acc == 3'b001, "R6 wrap to cluster0", 64'(acc), 64'h1);
    step(); chk(acc == 3'b100, "R6 then cluster2", 64'(acc), 64'h4);
    // R6: pointer passes the winner, skipping to cluster0 on bank 1
    set_req(1, 51'h08);
    step(); chk(acc == 3'b010, "R6 bank1 lone cluster1", 64'(acc), 64'h2);
    set_req(0, 51'h18);
    set_req(1, 51'h28);
    step(); chk(acc == 3'b001, "R6 pointer past winner picks cluster0", 64'(acc), 64'h1);
    step(); chk(acc == 3'b010, "R6 cluster1 afterwards", 64'(acc), 64'h2);
    drain();

    // R7/R8: bank 0 stalled, bank 1 flowing
    do_reset();
    br = 2'b10;
    set_req(0, 51'h40);
    step(); chk(acc == 3'b001, "R8 empty slot accepts", 64'(acc), 64'h1);
    set_req(1, 51'h80);
    set_req(2, 51'h48);
    step();
    chk(acc == 3'b100, "R8 stalled bank blocks, other bank flows", 64'(acc), 64'h4);
    chk(bank_valid[0] && bank_addr[0] == 51'h40, "R7 held request", 64'(bank_addr[0]), 64'h40);
    held_d = bank_data[0];
    for (int i = 0; i < 2; i++) begin
      step();
      chk(acc == 3'b000, "R8 still blocked", 64'(acc), 64'h0);
      chk(bank_valid[0] && bank_addr[0] == 51'h40 && bank_data[0] == held_d,
          "R7 held stable", 64'(bank_addr[0]), 64'h40);
    end
    br = 2'b11;
    step(); chk(acc == 3'b010, "R8 refill in same cycle as drain", 64'(acc), 64'h2);
    step(); chk(bank_addr[0] == 51'h80, "R7 new request follows", 64'(bank_addr[0]), 64'h80);
    drain();

    // random traffic with random stalls
    for (int i = 0; i < 600; i++) begin
      for (int c = 0; c < 3; c++) begin
        if (!pv[c] && ($urandom() % 3 != 0)) set_req(c, 51'({$urandom(), $urandom()}));
      end
      br = ($urandom() % 4 == 0) ? 2'($urandom()) : 2'b11;
      step();
    end
    drain();
    chk(qb0.size() == 0, "R3 bank0 queue empty", 64'(qb0.size()), 64'd0);
    chk(qb1.size() == 0, "R3 bank1 queue empty", 64'(qb1.size()), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule